// File: doc/BRIEF.md
# Auto-Increment Indirect Memory Window

This block sits behind a small set of host-visible registers and gives the host access to two internal stores: a word memory split into an instruction region and a data region, and a bank of peripheral registers. The host loads a pointer register first, then moves one 32-bit word per access through the matching data register. The memory window has separate read and write pointers. Each data access moves its own pointer forward by one dword, so a block of words streams through one register offset without reloading the address.

The peripheral window has a read pointer and a write pointer of its own. Each pointer holds a 16-bit byte offset and a two-bit field that encodes the transfer size as the number of bytes minus one. Peripheral accesses never advance their pointer. Any data access outside the mapped ranges reads as all-ones and writes nothing. Such an access also sets a sticky error output that only reset clears.

Top module: `imw_top`

## Requirements
- R1: After reset both memory pointers and both peripheral pointers read as zero, `rdValid` is low and `errFlag` is low.
- R2: Register offsets: 0x00 memory read pointer, 0x04 memory write pointer, 0x08 memory write data, 0x0C memory read data, 0x10 peripheral read pointer, 0x14 peripheral write pointer, 0x18 peripheral write data, 0x1C peripheral read data. A memory pointer keeps bits 23:0 of the written value, and bits 31:24 read back as zero.
- R3: A write to offset 0x08 stores the word at the memory write pointer, then advances that pointer by 4.
- R4: A read of offset 0x0C returns the word at the memory read pointer as it was before the access, then advances that pointer by 4. Every register read raises `rdValid` with its data in the cycle after the request.
- R5: The memory read pointer and the memory write pointer are independent. A data access through one pointer leaves the other unchanged.
- R6: Byte address A is in the instruction region when A < INST_WORDS*4, and in the data region when DATA_BASE <= A < DATA_BASE + DATA_WORDS*4. The defaults are 0x000000 to 0x0000FF and 0x800000 to 0x8000FF. Both ends of each region are accessible without error.
- R7: A memory data access outside both regions reads 0xFFFFFFFF and writes nothing. It does not alias any stored word, it still advances its pointer, and it sets `errFlag`. `errFlag` stays set until reset.
- R8: In a peripheral pointer, bits 15:0 hold the byte offset and bits 25:24 hold the byte count minus one. All other bits read back as zero.
- R9: A peripheral write with count field n updates byte lanes 0 to n of the word at offset bits 15:2, counting from the least significant byte. The other lanes keep their old value. Offset bits 1:0 do not shift the lanes.
- R10: A peripheral read returns lanes 0 to n of the addressed word, with the upper lanes zero. Peripheral data accesses never change either peripheral pointer.
- R11: A peripheral access whose word index (offset bits 15:2) is PER_WORDS or more (default 16) reads 0xFFFFFFFF. A write to such an index is dropped without aliasing, and either access sets `errFlag`.
- R12: A read of an unmapped offset, or of a write-data offset, returns zero. A write to an unmapped offset, or to a read-data offset, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Register write request, one per cycle |
| hostRdEn | input | 1 | Register read request, exclusive with write |
| hostAddr | input | 6 | Register byte offset |
| hostWrData | input | 32 | Write data |
| hostRdData | output | 32 | Read data, valid with `hostRdValid` |
| hostRdValid | output | 1 | Read data valid, one cycle after the request |
| errFlag | output | 1 | Sticky out-of-range access flag |

## Verification
A pointer that fails to advance, or advances when it should not, shows up at the next data read or pointer readback as a word from the wrong address or a wrong pointer value, one cycle after that read. A range check that is off by one, or an index that is truncated so it aliases, shows up as a missing error flag in the cycle after the access, or as corrupted boundary words read back later. Errors in byte-lane handling show up as wrong bytes in a peripheral word read back at a different count.

// File: rtl/imw_pkg.sv
package imw_pkg;

  localparam int WORD_W    = 32;
  localparam int LANES     = WORD_W / 8;
  localparam int REG_AW    = 6;
  localparam int PER_OFS_W = 16;
  localparam int PER_CNT_LO = 24;

  localparam logic [REG_AW-1:0] OFS_MEM_RPTR = 6'h00;
  localparam logic [REG_AW-1:0] OFS_MEM_WPTR = 6'h04;
  localparam logic [REG_AW-1:0] OFS_MEM_WDAT = 6'h08;
  localparam logic [REG_AW-1:0] OFS_MEM_RDAT = 6'h0C;
  localparam logic [REG_AW-1:0] OFS_PER_RPTR = 6'h10;
  localparam logic [REG_AW-1:0] OFS_PER_WPTR = 6'h14;
  localparam logic [REG_AW-1:0] OFS_PER_WDAT = 6'h18;
  localparam logic [REG_AW-1:0] OFS_PER_RDAT = 6'h1C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MEM_RPTR,
    SEL_MEM_WPTR,
    SEL_MEM_DATA,
    SEL_PER_RPTR,
    SEL_PER_WPTR,
    SEL_PER_DATA
  } rdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   rdReq;
    rdSel_e rdSel;
    logic   ldMemRptr;
    logic   ldMemWptr;
    logic   memWr;
    logic   memRd;
    logic   ldPerRptr;
    logic   ldPerWptr;
    logic   perWr;
    logic   perRd;
  } imwStrobe_t;

  // count field (bytes minus one) to lane enables, from lane 0 upward
  function automatic logic [LANES-1:0] laneEnables(input logic [1:0] cnt);
    logic [LANES-1:0] en;
    for (int l = 0; l < LANES; l++) en[l] = (2'(l) <= cnt);
    return en;
  endfunction

  function automatic logic [WORD_W-1:0] laneMask(input logic [LANES-1:0] en);
    logic [WORD_W-1:0] m;
    for (int l = 0; l < LANES; l++) m[8*l +: 8] = {8{en[l]}};
    return m;
  endfunction

endpackage

// File: rtl/imw_ram.sv
module imw_ram
  import imw_pkg::*;
#(
  parameter int WORDS = 64,
  localparam int IW = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LANES-1:0]  be,
  input  logic [IW-1:0]     wIdx,
  input  logic [WORD_W-1:0] wData,
  input  logic [IW-1:0]     rIdx,
  output logic [WORD_W-1:0] rData
);

  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (we && be[l]) mem[wIdx][8*l +: 8] <= wData[8*l +: 8];
    end
  end

  assign rData = mem[rIdx];

endmodule

// File: rtl/imw_ctrl.sv
module imw_ctrl
  import imw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [REG_AW-1:0] hostAddr,
  output imwStrobe_t        st,
  output logic              rdValid
);

  always_comb begin
    st       = '0;
    st.rdReq = hostRdEn;
    st.rdSel = SEL_NONE;
    if (hostWrEn) begin
      case (hostAddr)
        OFS_MEM_RPTR: st.ldMemRptr = 1'b1;
        OFS_MEM_WPTR: st.ldMemWptr = 1'b1;
        OFS_MEM_WDAT: st.memWr     = 1'b1;
        OFS_PER_RPTR: st.ldPerRptr = 1'b1;
        OFS_PER_WPTR: st.ldPerWptr = 1'b1;
        OFS_PER_WDAT: st.perWr     = 1'b1;
        default: ;
      endcase
    end
    if (hostRdEn) begin
      case (hostAddr)
        OFS_MEM_RPTR: st.rdSel = SEL_MEM_RPTR;
        OFS_MEM_WPTR: st.rdSel = SEL_MEM_WPTR;
        OFS_MEM_RDAT: begin st.rdSel = SEL_MEM_DATA; st.memRd = 1'b1; end
        OFS_PER_RPTR: st.rdSel = SEL_PER_RPTR;
        OFS_PER_WPTR: st.rdSel = SEL_PER_WPTR;
        OFS_PER_RDAT: begin st.rdSel = SEL_PER_DATA; st.perRd = 1'b1; end
        default: st.rdSel = SEL_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= hostRdEn;
  end

  // R4: every read request is answered in the following cycle
  p_rdvalid_next_r4: assert property (@(posedge clk) disable iff (!rstN)
    hostRdEn |=> rdValid);

  // R12: at most one state-changing strobe per host cycle
  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.ldMemRptr, st.ldMemWptr, st.memWr, st.memRd,
              st.ldPerRptr, st.ldPerWptr, st.perWr, st.perRd}));

  // R4: the host never reads and writes in the same cycle
  p_excl_req_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(hostWrEn && hostRdEn));

endmodule

// File: rtl/imw_datapath.sv
module imw_datapath
  import imw_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int INST_WORDS = 64,
  parameter int DATA_BASE  = 'h800000,
  parameter int DATA_WORDS = 64,
  parameter int PER_WORDS  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  imwStrobe_t        st,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              errFlag
);

  localparam int IIW = $clog2(INST_WORDS);
  localparam int DIW = $clog2(DATA_WORDS);
  localparam int PIW = $clog2(PER_WORDS);
  localparam logic [ADDR_W-1:0] INST_LIMIT = ADDR_W'(INST_WORDS * 4);
  localparam logic [ADDR_W-1:0] DATA_LO    = ADDR_W'(DATA_BASE);
  localparam logic [ADDR_W-1:0] DATA_LIMIT = ADDR_W'(DATA_BASE + DATA_WORDS * 4);
  localparam logic [ADDR_W-1:0] PTR_STEP   = ADDR_W'(4);

  // pointers
  logic [ADDR_W-1:0]    memRptr, memWptr;
  logic [PER_OFS_W-1:0] perROff, perWOff;
  logic [1:0]           perRCnt, perWCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memRptr <= '0;
      memWptr <= '0;
      perROff <= '0;
      perWOff <= '0;
      perRCnt <= '0;
      perWCnt <= '0;
    end else begin
      if (st.ldMemRptr)  memRptr <= wrData[ADDR_W-1:0];
      else if (st.memRd) memRptr <= memRptr + PTR_STEP;
      if (st.ldMemWptr)  memWptr <= wrData[ADDR_W-1:0];
      else if (st.memWr) memWptr <= memWptr + PTR_STEP;
      if (st.ldPerRptr) begin
        perROff <= wrData[PER_OFS_W-1:0];
        perRCnt <= wrData[PER_CNT_LO +: 2];
      end
      if (st.ldPerWptr) begin
        perWOff <= wrData[PER_OFS_W-1:0];
        perWCnt <= wrData[PER_CNT_LO +: 2];
      end
    end
  end

  logic unusedWrBits;
  assign unusedWrBits = ^{wrData[WORD_W-1:PER_CNT_LO+2], wrData[PER_CNT_LO-1:ADDR_W]};

  // range decode for both memory pointers
  logic rInst, rData, wInst, wData;
  assign rInst = (memRptr < INST_LIMIT);
  assign rData = (memRptr >= DATA_LO) && (memRptr < DATA_LIMIT);
  assign wInst = (memWptr < INST_LIMIT);
  assign wData = (memWptr >= DATA_LO) && (memWptr < DATA_LIMIT);

  logic [ADDR_W-1:0] rDataOff, wDataOff;
  assign rDataOff = memRptr - DATA_LO;
  assign wDataOff = memWptr - DATA_LO;

  logic [IIW-1:0] rInstIdx, wInstIdx;
  logic [DIW-1:0] rDataIdx, wDataIdx;
  assign rInstIdx = memRptr[IIW+1:2];
  assign wInstIdx = memWptr[IIW+1:2];
  assign rDataIdx = rDataOff[DIW+1:2];
  assign wDataIdx = wDataOff[DIW+1:2];

  logic unusedOffBits;
  assign unusedOffBits = ^{rDataOff[ADDR_W-1:DIW+2], wDataOff[ADDR_W-1:DIW+2],
                           rDataOff[1:0], wDataOff[1:0]};

  // peripheral decode
  logic perRIn, perWIn;
  assign perRIn = (perROff[PER_OFS_W-1:2] < (PER_OFS_W-2)'(PER_WORDS));
  assign perWIn = (perWOff[PER_OFS_W-1:2] < (PER_OFS_W-2)'(PER_WORDS));

  logic [LANES-1:0] perWBe, perRBe;
  assign perWBe = laneEnables(perWCnt);
  assign perRBe = laneEnables(perRCnt);

  // storage
  logic [WORD_W-1:0] instRd, dataRd, perRd;

  imw_ram #(.WORDS(INST_WORDS)) instRam_i (
    .clk(clk), .we(st.memWr && wInst), .be('1), .wIdx(wInstIdx),
    .wData(wrData), .rIdx(rInstIdx), .rData(instRd));

  imw_ram #(.WORDS(DATA_WORDS)) dataRam_i (
    .clk(clk), .we(st.memWr && wData), .be('1), .wIdx(wDataIdx),
    .wData(wrData), .rIdx(rDataIdx), .rData(dataRd));

  imw_ram #(.WORDS(PER_WORDS)) perRam_i (
    .clk(clk), .we(st.perWr && perWIn), .be(perWBe), .wIdx(perWOff[PIW+1:2]),
    .wData(wrData), .rIdx(perROff[PIW+1:2]), .rData(perRd));

  // read mux
  logic [WORD_W-1:0] rdMux;
  always_comb begin
    unique case (st.rdSel)
      SEL_MEM_RPTR: rdMux = WORD_W'(memRptr);
      SEL_MEM_WPTR: rdMux = WORD_W'(memWptr);
      SEL_MEM_DATA: rdMux = rInst ? instRd : (rData ? dataRd : '1);
      SEL_PER_RPTR: rdMux = {6'b0, perRCnt, 8'b0, perROff};
      SEL_PER_WPTR: rdMux = {6'b0, perWCnt, 8'b0, perWOff};
      SEL_PER_DATA: rdMux = perRIn ? (perRd & laneMask(perRBe)) : '1;
      default:      rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rdData <= '0;
    else if (st.rdReq) rdData <= rdMux;
  end

  // sticky range error
  logic badAccess;
  assign badAccess = (st.memWr && !(wInst || wData)) || (st.memRd && !(rInst || rData)) ||
                     (st.perWr && !perWIn) || (st.perRd && !perRIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          errFlag <= 1'b0;
    else if (badAccess) errFlag <= 1'b1;
  end

  // R4: a memory data read advances the read pointer one dword
  p_rptr_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    st.memRd |=> memRptr == $past(memRptr) + PTR_STEP);

  // R3: a memory data write advances the write pointer one dword
  p_wptr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    st.memWr |=> memWptr == $past(memWptr) + PTR_STEP);

  // R5: each pointer ignores the other pointer's data accesses
  p_wptr_indep_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.memRd |=> $stable(memWptr));
  p_rptr_indep_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.memWr |=> $stable(memRptr));

  // R7: error flag is sticky
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R7: out-of-range memory read yields all-ones
  p_oob_ones_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st.memRd && !rInst && !rData) |=> (rdData == '1) && errFlag);

  // R10: peripheral data accesses leave both peripheral pointers alone
  p_per_noinc_r10: assert property (@(posedge clk) disable iff (!rstN)
    (st.perRd || st.perWr) |=> $stable(perROff) && $stable(perWOff) &&
                               $stable(perRCnt) && $stable(perWCnt));

endmodule

// File: rtl/imw_top.sv
module imw_top
  import imw_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int INST_WORDS = 64,
  parameter int DATA_BASE  = 'h800000,
  parameter int DATA_WORDS = 64,
  parameter int PER_WORDS  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [REG_AW-1:0] hostAddr,
  input  logic [WORD_W-1:0] hostWrData,
  output logic [WORD_W-1:0] hostRdData,
  output logic              hostRdValid,
  output logic              errFlag
);

  imwStrobe_t st;

  imw_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .st(st), .rdValid(hostRdValid));

  imw_datapath #(
    .ADDR_W(ADDR_W), .INST_WORDS(INST_WORDS), .DATA_BASE(DATA_BASE),
    .DATA_WORDS(DATA_WORDS), .PER_WORDS(PER_WORDS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .wrData(hostWrData),
    .rdData(hostRdData), .errFlag(errFlag));

endmodule

// File: tb/imw_top_tb_top.sv
`timescale 1ns/1ps
module imw_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic        hostRdEn = 1'b0;
  logic [5:0]  hostAddr = '0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        hostRdValid;
  logic        errFlag;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  localparam logic [5:0] A_MRP = 6'h00, A_MWP = 6'h04, A_MWD = 6'h08, A_MRD = 6'h0C;
  localparam logic [5:0] A_PRP = 6'h10, A_PWP = 6'h14, A_PWD = 6'h18, A_PRD = 6'h1C;

  always #10 clk = ~clk;

  imw_top dut_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .hostRdValid(hostRdValid), .errFlag(errFlag));

  task automatic hostWrite(input logic [5:0] a, input logic [31:0] d);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [5:0] a, input logic [31:0] e, input string tag);
    expQ.push_back(e);
    tagQ.push_back(tag);
    hostRdEn = 1'b1; hostAddr = a;
    @(negedge clk);
    hostRdEn = 1'b0;
  endtask

  task automatic checkBit(input logic act, input logic e, input string tag);
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, e);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // monitor: compare each returned word against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && hostRdValid) begin
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R4 unexpected read data actual=%08h expected=none", hostRdData);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (hostRdData !== e) begin
          bad++;
          $display("FAIL %s actual=%08h expected=%08h", t, hostRdData, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R4 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkBit(hostRdValid, 1'b0, "R1 rdValid after reset");
    checkBit(errFlag, 1'b0, "R1 errFlag after reset");
    hostRead(A_MRP, 32'h0, "R1 mem read ptr");
    hostRead(A_MWP, 32'h0, "R1 mem write ptr");
    hostRead(A_PRP, 32'h0, "R1 per read ptr");
    hostRead(A_PWP, 32'h0, "R1 per write ptr");

    // R2 pointer load and readback
    hostWrite(A_MWP, 32'hAB80_0020);
    hostRead(A_MWP, 32'h0080_0020, "R2 write ptr upper bits dropped");
    hostWrite(A_MRP, 32'h0000_0010);
    hostRead(A_MRP, 32'h0000_0010, "R2 read ptr readback");

    // R3 streaming writes
    hostWrite(A_MWP, 32'h20);
    for (int i = 0; i < 4; i++) hostWrite(A_MWD, 32'hA000_0000 + i);
    hostRead(A_MWP, 32'h30, "R3 write ptr after 4 writes");

    // R4 streaming reads, value before increment
    hostWrite(A_MRP, 32'h20);
    for (int i = 0; i < 4; i++) hostRead(A_MRD, 32'hA000_0000 + i, "R4 streamed word");
    hostRead(A_MRP, 32'h30, "R4 read ptr after 4 reads");

    // R5 independent pointers
    hostWrite(A_MWP, 32'h80_0000);
    hostWrite(A_MRP, 32'h24);
    hostWrite(A_MWD, 32'hD0D0_0000);
    hostRead(A_MRD, 32'hA000_0001, "R5 read ptr unaffected by write");
    hostRead(A_MWP, 32'h80_0004, "R5 write ptr unaffected by read");
    hostRead(A_MRP, 32'h28, "R5 read ptr stepped once");
    hostWrite(A_MRP, 32'h80_0000);
    hostRead(A_MRD, 32'hD0D0_0000, "R6 data region first word");

    // R6 region ends
    hostWrite(A_MWP, 32'hFC);
    hostWrite(A_MWD, 32'h1111_FFFC);
    hostWrite(A_MWP, 32'h80_00FC);
    hostWrite(A_MWD, 32'h2222_FFFC);
    hostWrite(A_MWP, 32'h0);
    hostWrite(A_MWD, 32'h5A5A_0000);
    hostWrite(A_MRP, 32'hFC);
    hostRead(A_MRD, 32'h1111_FFFC, "R6 last instruction word");
    hostWrite(A_MRP, 32'h80_00FC);
    hostRead(A_MRD, 32'h2222_FFFC, "R6 last data word");
    checkBit(errFlag, 1'b0, "R6 no error inside regions");

    // R7 out of range
    hostWrite(A_MWP, 32'h100);
    hostWrite(A_MWD, 32'hDEAD_BEEF);
    checkBit(errFlag, 1'b1, "R7 error after write past instruction end");
    hostWrite(A_MRP, 32'h0);
    hostRead(A_MRD, 32'h5A5A_0000, "R7 dropped write did not alias word 0");
    hostWrite(A_MWP, 32'h7F_FFFC);
    hostWrite(A_MWD, 32'h0000_0013);
    hostWrite(A_MRP, 32'h80_0100);
    hostRead(A_MRD, 32'hFFFF_FFFF, "R7 read past data end");
    hostRead(A_MRP, 32'h80_0104, "R7 pointer still steps");
    hostWrite(A_MRP, 32'h80_00FC);
    hostRead(A_MRD, 32'h2222_FFFC, "R7 write below data base did not alias");
    checkBit(errFlag, 1'b1, "R7 error stays set");

    repeat (2) @(negedge clk);
    doReset();
    checkBit(errFlag, 1'b0, "R1 error cleared by reset");
    hostRead(A_MRP, 32'h0, "R1 read ptr cleared by reset");

    // R12 unmapped and wrong-direction offsets
    hostWrite(6'h24, 32'h1234_5678);
    hostWrite(A_MRD, 32'h0000_0040);
    hostRead(6'h24, 32'h0, "R12 unmapped offset reads zero");
    hostRead(A_MWD, 32'h0, "R12 write-data offset reads zero");
    hostRead(A_MWP, 32'h0, "R12 unmapped write left write ptr");
    hostRead(A_MRP, 32'h0, "R12 write to read-data offset ignored");

    // R8 peripheral pointer fields
    hostWrite(A_PRP, 32'hFFFF_FFFF);
    hostRead(A_PRP, 32'h0300_FFFF, "R8 only offset and count kept");
    hostWrite(A_PWP, 32'h0100_0008);
    hostRead(A_PWP, 32'h0100_0008, "R8 write ptr fields");

    // R9 byte lanes from LSB
    hostWrite(A_PWP, 32'h0300_0008);
    hostWrite(A_PWD, 32'h1122_3344);
    hostWrite(A_PWP, 32'h0000_0008);
    hostWrite(A_PWD, 32'hAABB_CCDD);
    hostWrite(A_PWP, 32'h0100_0008);
    hostWrite(A_PWD, 32'h5566_EEFF);
    hostWrite(A_PRP, 32'h0300_0008);
    hostRead(A_PRD, 32'h1122_EEFF, "R9 merged lanes");
    hostRead(A_PRD, 32'h1122_EEFF, "R10 no increment on read");
    hostRead(A_PRP, 32'h0300_0008, "R10 read ptr unchanged");
    hostRead(A_PWP, 32'h0100_0008, "R10 write ptr unchanged");
    hostWrite(A_PRP, 32'h0000_0008);
    hostRead(A_PRD, 32'h0000_00FF, "R10 one-byte read");
    hostWrite(A_PRP, 32'h0200_0008);
    hostRead(A_PRD, 32'h0022_EEFF, "R10 three-byte read");
    hostWrite(A_PRP, 32'h0300_000B);
    hostRead(A_PRD, 32'h1122_EEFF, "R9 low offset bits do not shift lanes");
    hostWrite(A_PWP, 32'h0300_003C);
    hostWrite(A_PWD, 32'h0000_0077);
    hostWrite(A_PRP, 32'h0300_003C);
    hostRead(A_PRD, 32'h0000_0077, "R11 last peripheral word");
    checkBit(errFlag, 1'b0, "R11 no error inside peripheral range");

    // R11 peripheral out of range
    hostWrite(A_PWP, 32'h0300_0000);
    hostWrite(A_PWD, 32'hCAFE_F00D);
    hostWrite(A_PWP, 32'h0300_0040);
    hostWrite(A_PWD, 32'h0BAD_F00D);
    checkBit(errFlag, 1'b1, "R11 error after out-of-range write");
    hostWrite(A_PRP, 32'h0300_0000);
    hostRead(A_PRD, 32'hCAFE_F00D, "R11 dropped write did not alias");
    hostWrite(A_PRP, 32'h0300_0040);
    hostRead(A_PRD, 32'hFFFF_FFFF, "R11 out-of-range read");

    repeat (3) @(negedge clk);
    total++;
    if (expQ.size() != 0) begin
      bad++;
      $display("FAIL R4 missing read data actual=%0d expected=0", expQ.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule